// File: doc/BRIEF.md
# Pipelined Serial ADC Scan Controller

This block is the master side of a full-duplex serial link to a multi-channel converter. It cycles through channels 0 to 8 without stopping. Every 16-bit frame shifts out the address of one channel while it shifts in the conversion that the converter made for the address sent in the frame before. The received word is left-justified, so the block shifts it right by six places to form a 10-bit result. It then writes the result into a per-channel register bank and announces it with a one-clock strobe that carries the channel index.

Between frames the converter needs time to convert. In counted mode the block waits a fixed number of system clocks. In handshake mode it waits until the converter raises an end-of-conversion line. A configuration bit selects whether a frame goes out as one unbroken 16-bit burst or as two 8-bit bursts. In the split form the serial clock is held low for a gap between the two halves while chip select stays asserted. Downstream logic can read any channel's latest result through a registered read port.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While `rst` is high and on the first clock after it, `cs_n` is 1, `sclk` is 0 and `res_valid` is 0. After reset the first frame starts without any wait and carries channel address 0.
- R2: Frame k after reset (k = 0, 1, 2, ...) sends channel k mod 9. The address goes out MSB first as the first 4 bits of the 16-bit frame, and the last 12 bits are 0.
- R3: `sclk` is 0 whenever `cs_n` is 1. `cs_n` stays 0 for the whole frame, and each frame has exactly 16 rising edges of `sclk`. `mosi` changes only on a falling edge of `sclk`, and `miso` is sampled on each rising edge.
- R4: The data returned in the first frame after reset is discarded. No `res_valid` pulse occurs before the second frame has ended.
- R5: The result stored at the end of frame k (k >= 1) is tagged with the channel sent in frame k-1. Its value is the received 16-bit word shifted right by 6, which is the first 10 bits received. The last 6 received bits have no effect, even when they are nonzero.
- R6: `res_valid` is high for exactly one clock, on the clock after `cs_n` rises, once per frame from the second frame on. `res_chan` and `res_data` are valid in that cycle.
- R7: With `cfg_eoc_mode` = 0, `cs_n` stays high for exactly WAIT_CYCLES+1 clocks between frames (45 by default). This is the end-of-frame clock plus 44 counted wait clocks.
- R8: With `cfg_eoc_mode` = 1, the next frame starts on the first clock edge after the previous frame at which `eoc` is sampled high, and `cs_n` falls at that edge. The fixed count plays no part, whether `eoc` comes sooner or later than 44 clocks.
- R9: With `cfg_split` = 1, `sclk` is held low for GAP_CYCLES extra clocks between bit 8 and bit 9 while `cs_n` stays low. With `cfg_split` = 0 there is no such gap. The bits of the frame are the same in both forms.
- R10: `rd_data` gives the most recent result stored for channel `rd_chan`, one clock after `rd_chan` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_eoc_mode | input | 1 | 1: wait for end-of-conversion, 0: fixed clock count |
| cfg_split | input | 1 | 1: send frame as two 8-bit bursts with a gap |
| eoc | input | 1 | End-of-conversion from the converter |
| miso | input | 1 | Serial data from the converter |
| rd_chan | input | 4 | Channel index for the result read port |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| res_valid | output | 1 | One-clock strobe when a result is stored |
| res_chan | output | 4 | Channel of the stored result |
| res_data | output | 10 | Stored 10-bit result |
| rd_data | output | 10 | Registered result read for `rd_chan` |

## Verification
The bench models the converter. It returns a different value for every channel and puts nonzero junk in the six trailing bits, so a design that skips the right shift, or that tags the result with the address being sent instead of the one sent before, stores wrong values. The first frame after a reset returns all ones; a design that keeps that data would strobe early. Reset is also applied in the middle of a frame, where a design that kept its channel pointer would restart at the wrong channel. Chip select high time is measured in both wait modes: counted mode must give 45 clocks, and handshake mode uses end-of-conversion delays shorter and longer than 44 so that a design still using the count starts too early or too late. The longest serial-clock low time in each frame shows whether the gap between the two 8-bit bursts is present exactly when it is configured.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    E_IDLE,
    E_SHIFT,
    E_GAP
  } eng_state_t;

  typedef enum logic [1:0] {
    T_BOOT,
    T_FRAME,
    T_WAIT
  } seq_state_t;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(CLK_DIV + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == CNT_LAST);

endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int WAIT_CYCLES = 44
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic clear,
  input  logic eoc_mode,
  input  logic eoc,
  output logic ready
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CYCLES - 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (arm) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (clear) begin
      active <= 1'b0;
    end else if (active && cnt != CNT_LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ready = active && (eoc_mode ? eoc : (cnt == CNT_LAST));

endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
  import adc_scan_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 10,
  parameter int SPLIT_AT   = 8,
  parameter int GAP_CYCLES = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  split,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic                  tick,
  input  logic                  miso,
  output logic                  run,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  done,
  output logic [RES_BITS-1:0]   rx_res
);
  localparam int BW     = $clog2(FRAME_BITS);
  localparam int GW     = $clog2(GAP_CYCLES + 1);
  localparam int OFFSET = FRAME_BITS - RES_BITS;
  localparam logic [BW-1:0] LAST_BIT  = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] SPLIT_BIT = BW'(SPLIT_AT - 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYCLES - 1);

  eng_state_t            st;
  logic [FRAME_BITS-2:0] sh_tx;
  logic [FRAME_BITS-1:0] rx_word;
  logic [BW-1:0]         bit_idx;
  logic [GW-1:0]         gap_cnt;

  assign run    = (st == E_SHIFT);
  assign rx_res = RES_BITS'(rx_word >> OFFSET);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      sh_tx   <= '0;
      rx_word <= '0;
      bit_idx <= '0;
      gap_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start) begin
            cs_n    <= 1'b0;
            sclk    <= 1'b0;
            mosi    <= tx_word[FRAME_BITS-1];
            sh_tx   <= tx_word[FRAME_BITS-2:0];
            bit_idx <= '0;
            st      <= E_SHIFT;
          end
        end
        E_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk    <= 1'b1;
              rx_word <= {rx_word[FRAME_BITS-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bit_idx == LAST_BIT) begin
                cs_n <= 1'b1;
                mosi <= 1'b0;
                done <= 1'b1;
                st   <= E_IDLE;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                mosi    <= sh_tx[FRAME_BITS-2];
                sh_tx   <= {sh_tx[FRAME_BITS-3:0], 1'b0};
                if (split && bit_idx == SPLIT_BIT) begin
                  gap_cnt <= '0;
                  st      <= E_GAP;
                end
              end
            end
          end
        end
        E_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            st <= E_SHIFT;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int ADDR_BITS = 4,
  parameter int WIDTH     = 10
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [WIDTH-1:0]     wr_data,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [WIDTH-1:0]     rd_data
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH      = 9,
  parameter int ADDR_BITS   = 4,
  parameter int FRAME_BITS  = 16,
  parameter int RES_BITS    = 10,
  parameter int WAIT_CYCLES = 44,
  parameter int CLK_DIV     = 2,
  parameter int SPLIT_AT    = 8,
  parameter int GAP_CYCLES  = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_eoc_mode,
  input  logic                 cfg_split,
  input  logic                 eoc,
  input  logic                 miso,
  input  logic [ADDR_BITS-1:0] rd_chan,
  output logic                 cs_n,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 res_valid,
  output logic [ADDR_BITS-1:0] res_chan,
  output logic [RES_BITS-1:0]  res_data,
  output logic [RES_BITS-1:0]  rd_data
);
  localparam int PAD = FRAME_BITS - ADDR_BITS;
  localparam logic [ADDR_BITS-1:0] LAST_CH = ADDR_BITS'(NUM_CH - 1);

  seq_state_t            st;
  logic [ADDR_BITS-1:0]  tx_chan;
  logic [ADDR_BITS-1:0]  prev_chan;
  logic                  have_prev;
  logic                  start;
  logic                  wait_ready;
  logic                  tick;
  logic                  run;
  logic                  frame_done;
  logic                  store;
  logic [RES_BITS-1:0]   rx_res;
  logic [FRAME_BITS-1:0] tx_word;

  assign tx_word = {tx_chan, {PAD{1'b0}}};
  assign start   = (st == T_BOOT) || (st == T_WAIT && wait_ready);
  assign store   = (st == T_FRAME) && frame_done && have_prev;

  adc_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  adc_frame_engine #(
    .FRAME_BITS (FRAME_BITS),
    .RES_BITS   (RES_BITS),
    .SPLIT_AT   (SPLIT_AT),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .split   (cfg_split),
    .tx_word (tx_word),
    .tick    (tick),
    .miso    (miso),
    .run     (run),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .mosi    (mosi),
    .done    (frame_done),
    .rx_res  (rx_res)
  );

  adc_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .arm      (frame_done),
    .clear    (start),
    .eoc_mode (cfg_eoc_mode),
    .eoc      (eoc),
    .ready    (wait_ready)
  );

  adc_result_bank #(.ADDR_BITS(ADDR_BITS), .WIDTH(RES_BITS)) u_bank (
    .clk     (clk),
    .wr_en   (store),
    .wr_addr (prev_chan),
    .wr_data (rx_res),
    .rd_addr (rd_chan),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_BOOT;
      tx_chan   <= '0;
      prev_chan <= '0;
      have_prev <= 1'b0;
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        T_BOOT: st <= T_FRAME;
        T_FRAME: begin
          if (frame_done) begin
            st <= T_WAIT;
            if (have_prev) begin
              res_valid <= 1'b1;
              res_chan  <= prev_chan;
              res_data  <= rx_res;
            end
            prev_chan <= tx_chan;
            have_prev <= 1'b1;
            tx_chan   <= (tx_chan == LAST_CH) ? '0 : tx_chan + 1'b1;
          end
        end
        T_WAIT: begin
          if (wait_ready) st <= T_FRAME;
        end
        default: st <= T_BOOT;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int NUM_CH      = 9,
  parameter int ADDR_BITS   = 4,
  parameter int WAIT_CYCLES = 44
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_eoc_mode,
  input logic                 eoc,
  input logic                 cs_n,
  input logic                 sclk,
  input logic                 mosi,
  input logic                 res_valid,
  input logic [ADDR_BITS-1:0] res_chan
);
  logic [15:0] hi_cnt;
  logic        seen_low;
  logic        prev_cs;
  logic [1:0]  rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      seen_low <= 1'b0;
      prev_cs  <= 1'b1;
      rises    <= '0;
    end else begin
      hi_cnt  <= cs_n ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
      prev_cs <= cs_n;
      if (!cs_n) seen_low <= 1'b1;
      if (cs_n && !prev_cs && rises != 2'd2) rises <= rises + 1'b1;
    end
  end

  assert_idle_clock_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_mosi_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi));

  assert_first_discard_R4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (rises == 2'd2));

  assert_chan_range_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_chan < ADDR_BITS'(NUM_CH)));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_pulse_after_frame_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (cs_n && $past(cs_n) && !$past(cs_n, 2)));

  assert_fixed_gap_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && !cfg_eoc_mode && seen_low) |-> (hi_cnt == 16'(WAIT_CYCLES + 1)));

  assert_eoc_gate_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && cfg_eoc_mode && seen_low) |-> $past(eoc));

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
  .NUM_CH      (NUM_CH),
  .ADDR_BITS   (ADDR_BITS),
  .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_eoc_mode (cfg_eoc_mode),
  .eoc          (eoc),
  .cs_n         (cs_n),
  .sclk         (sclk),
  .mosi         (mosi),
  .res_valid    (res_valid),
  .res_chan     (res_chan)
);

// File: tb/adc_scan_ctrl_tb.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 44;
  localparam int GAP_CYC    = 20;
  localparam int DIV        = 2;
  localparam int NCH        = 9;

  // {eoc_mode, split, salt[5:0], eoc_delay[7:0]}
  localparam logic [15:0] VEC [4] = '{
    {1'b0, 1'b0, 6'h03, 8'd0},
    {1'b0, 1'b1, 6'h15, 8'd0},
    {1'b1, 1'b0, 6'h2A, 8'd100},
    {1'b1, 1'b1, 6'h3F, 8'd7}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_eoc_mode = 1'b0;
  logic       cfg_split = 1'b0;
  logic       eoc;
  logic       miso;
  logic [3:0] rd_chan = 4'd0;
  logic       cs_n, sclk, mosi, res_valid;
  logic [3:0] res_chan;
  logic [9:0] res_data, rd_data;

  logic [5:0] salt = 6'h03;
  int         eoc_delay = 0;
  bit         finished = 1'b0;

  adc_scan_ctrl #(
    .WAIT_CYCLES (WAIT_CYC),
    .CLK_DIV     (DIV),
    .GAP_CYCLES  (GAP_CYC)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_eoc_mode(cfg_eoc_mode), .cfg_split(cfg_split),
    .eoc(eoc), .miso(miso), .rd_chan(rd_chan), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] conv(input logic [3:0] a, input logic [5:0] s);
    logic [9:0] r;
    r = {6'd0, a} * 10'd89 + {4'd0, s} * 10'd37 + 10'd5;
    return r;
  endfunction

  function automatic int chk(input bit ok, input string tag, input int act, input int exp);
    if (!ok) $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    return ok ? 0 : 1;
  endfunction

  // converter model: serial side
  int falls_total = 0;
  int rises_total = 0;
  int falls_at_start, rises_at_start, started;
  logic [15:0] s_cap = '0;
  logic [15:0] s_word;
  int idx;

  always @(negedge sclk) if (!cs_n) falls_total = falls_total + 1;
  always @(posedge sclk) if (!cs_n) begin
    rises_total = rises_total + 1;
    s_cap = {s_cap[14:0], mosi};
  end

  always @(negedge cs_n or posedge rst) begin
    if (rst) started = 0;
    else begin
      falls_at_start = falls_total;
      rises_at_start = rises_total;
      started = started + 1;
    end
  end

  assign idx  = falls_total - falls_at_start;
  assign miso = (idx >= 0 && idx < 16) ? s_word[15 - idx] : 1'b0;

  // frame end: address checks and expected result
  int frames, nc_d, nb_d;
  logic [3:0] exp_addr, prev_addr, exp_chan;
  logic [9:0] exp_data;
  bit have_prev;
  initial begin nc_d = 0; nb_d = 0; end

  always @(posedge cs_n or posedge rst) begin
    if (rst) begin
      frames = 0; exp_addr = 4'd0; have_prev = 1'b0;
      s_word = 16'hFFFF;
      exp_chan = 4'd0; exp_data = 10'd0; prev_addr = 4'd0;
    end else if (started > frames) begin
      if (frames == 0) begin
        nc_d++; nb_d += chk(s_cap[15:12] == 4'd0, "R1 first address", s_cap[15:12], 0);
      end
      nc_d++; nb_d += chk(s_cap[15:12] == exp_addr, "R2 address", s_cap[15:12], exp_addr);
      nc_d++; nb_d += chk(s_cap[11:0] == 12'd0, "R2 trailing bits", s_cap[11:0], 0);
      nc_d++; nb_d += chk(rises_total - rises_at_start == 16, "R3 clock count",
                          rises_total - rises_at_start, 16);
      if (have_prev) begin
        exp_chan = prev_addr;
        exp_data = conv(prev_addr, salt);
      end
      prev_addr = exp_addr;
      have_prev = 1'b1;
      s_word = {conv(exp_addr, salt), salt ^ 6'h2D};
      exp_addr = (exp_addr == 4'd8) ? 4'd0 : exp_addr + 4'd1;
      frames = frames + 1;
    end
  end

  // end-of-conversion model
  int ecnt;
  always @(negedge clk) begin
    if (rst || !cs_n) begin
      eoc <= 1'b0; ecnt <= 0;
    end else if (ecnt == eoc_delay) eoc <= 1'b1;
    else ecnt <= ecnt + 1;
  end

  // sampled monitor: strobes, gaps, serial clock low time
  int nc_e = 0, nb_e = 0, strobes, hi_run, lr, lrmax;
  bit cs_p, cs_p2, val_p, seen;
  always @(negedge clk) begin
    if (rst) begin
      strobes = 0; hi_run = 0; lr = 0; lrmax = 0;
      cs_p = 1'b1; cs_p2 = 1'b1; val_p = 1'b0; seen = 1'b0;
    end else begin
      if (res_valid) begin
        strobes++;
        nc_e++; nb_e += chk(frames >= 2, "R4 early strobe", frames, 2);
        nc_e++; nb_e += chk(res_chan == exp_chan, "R5 channel", res_chan, exp_chan);
        nc_e++; nb_e += chk(res_data == exp_data, "R5 data", res_data, exp_data);
        nc_e++; nb_e += chk(cs_n && cs_p && !cs_p2, "R6 strobe timing", {cs_n, cs_p, cs_p2}, 3'b110);
        nc_e++; nb_e += chk(!val_p, "R6 strobe width", val_p, 0);
      end
      if (cs_n) hi_run++;
      else begin
        if (cs_p && seen) begin
          nc_e++;
          if (cfg_eoc_mode) nb_e += chk(hi_run == eoc_delay + 1, "R8 handshake gap", hi_run, eoc_delay + 1);
          else nb_e += chk(hi_run == WAIT_CYC + 1, "R7 fixed gap", hi_run, WAIT_CYC + 1);
        end
        hi_run = 0;
        seen = 1'b1;
        if (!sclk) begin lr++; if (lr > lrmax) lrmax = lr; end
        else lr = 0;
      end
      if (cs_n && !cs_p) begin
        nc_e++;
        if (cfg_split) nb_e += chk(lrmax >= GAP_CYC, "R9 split gap", lrmax, GAP_CYC);
        else nb_e += chk(lrmax < GAP_CYC, "R9 continuous", lrmax, GAP_CYC);
        lr = 0; lrmax = 0;
      end
      cs_p2 = cs_p; cs_p = cs_n; val_p = res_valid;
    end
  end

  // main sequence
  int nc_m = 0, nb_m = 0, nc_w = 0, nb_w = 0;

  task automatic hold_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    nc_m++; nb_m += chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    nc_m++; nb_m += chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
    nc_m++; nb_m += chk(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
    rst = 1'b0;
  endtask

  task automatic run_frames(input int n);
    while (frames < n) @(negedge clk);
    while (cs_n) @(negedge clk);
    nc_m++; nb_m += chk(strobes == frames - 1, "R6 strobe count", strobes, frames - 1);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rst = 1'b1;
      cfg_eoc_mode = VEC[i][15];
      cfg_split    = VEC[i][14];
      salt         = VEC[i][13:8];
      eoc_delay    = int'(VEC[i][7:0]);
      hold_reset();
      run_frames(20);
      for (int c = 0; c < NCH; c++) begin
        rd_chan = 4'(c);
        @(negedge clk);
        nc_m++; nb_m += chk(rd_data == conv(4'(c), salt), "R10 bank read", rd_data, conv(4'(c), salt));
      end
    end

    // directed: reset in the middle of a frame
    cfg_eoc_mode = 1'b0; cfg_split = 1'b0; salt = 6'h11; eoc_delay = 0;
    hold_reset();
    while (!(frames == 3 && !cs_n)) @(negedge clk);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    nc_m++; nb_m += chk(cs_n == 1'b1, "R1 cs_n after mid-frame reset", cs_n, 1);
    nc_m++; nb_m += chk(sclk == 1'b0, "R1 sclk after mid-frame reset", sclk, 0);
    nc_m++; nb_m += chk(res_valid == 1'b0, "R1 strobe after mid-frame reset", res_valid, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_frames(12);
    rd_chan = 4'd8;
    @(negedge clk);
    nc_m++; nb_m += chk(rd_data == conv(4'd8, salt), "R10 bank read last channel", rd_data, conv(4'd8, salt));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nc_m + nc_d + nc_e, nb_m + nb_d + nb_e);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nc_w = 1; nb_w = 1;
      $display("FAIL watchdog: act=%0d exp=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", nc_m + nc_d + nc_e + nc_w, nb_m + nb_d + nb_e + nb_w);
      $finish;
    end
  end

endmodule